// File: doc/BRIEF.md
# Shared-CRC Ethernet Loopback Datapath

This block is the byte-wide loopback path of an Ethernet MAC. It is built around one CRC-32 frame check engine, and that engine can serve only one side of the path for any given frame. When the transmit side owns the engine, it computes the frame check sequence and appends it after the last payload byte. When the receive side owns it, the transmit buffer goes through untouched and must already end in a four-byte check sequence. The receive side then checks that sequence. It also hashes the destination address against a 64-bit logical address filter to decide on multicast acceptance.

An ownership input, `crcToRx`, selects the owner. Its value is taken once per frame, with the first byte, so a change during a frame has no effect until the next one. Two side outputs follow from the loopback configuration. Runt acceptance is forced on whenever loopback is active, and collision detection is switched off in external loopback on the twisted-pair port. Transmitted bytes come out on the receive side when loopback is enabled. They are marked as going to the wire except during internal loopback.

Top module: `lb_crc_path`

## Requirements
- R1: The engine owner for a frame is `crcToRx` sampled with the accepted start-of-frame byte. Later changes to `crcToRx` within the same frame change neither appending nor checking.
- R2: With the transmit side as owner, four extra bytes follow the last payload byte on the output. Byte k (k = 0..3) is bits [8k+7:8k] of the complemented CRC register. `rxEof` is on the fourth appended byte, and `txReady` is low during the four append cycles.
- R3: With the transmit side as owner, `fcsErr` and `mcastAccept` stay 0, even for a frame whose first byte has bit 0 set and whose filter bits are all ones.
- R4: With the receive side as owner, the output byte stream equals the input stream with no bytes added, and `rxEof` is on the last input byte.
- R5: With the receive side as owner, `fcsErr` is set together with the last output byte when the CRC register is not 0xDEBB20E3 after the last byte. This value is the bit-reversed form of residue 0xC704DD7B. `fcsErr` is cleared on the next start of frame and does not change otherwise.
- R6: With the receive side as owner, `mcastAccept` is set with the sixth output byte when bit 0 of the first byte is 1 and `addrFilter[idx]` is 1. Here idx is bits [5:0] of the CRC register after the first six bytes. The flag is cleared on the next start of frame. Frames shorter than six bytes never set it.
- R7: `runtAccept` equals `runtCfg OR loopEn`.
- R8: `collisionEn` is 0 exactly when `loopEn`, `extLoop` and `tpSelect` are all 1.
- R9: Output bytes appear on `rxValid` only while `loopEn` is 1. `netTxEn` marks each output byte unless internal loopback is active (`loopEn`=1, `extLoop`=0).
- R10: Frames of any length, including a single byte with start and end together, are handled in both ownership modes. The output follows the accepted byte by one clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| txValid | input | 1 | Transmit byte valid |
| txByte | input | 8 | Transmit byte |
| txSof | input | 1 | First byte of frame |
| txEof | input | 1 | Last byte of frame |
| txReady | output | 1 | Byte accepted this cycle when high |
| crcToRx | input | 1 | 1: engine to receive side, 0: to transmit side |
| loopEn | input | 1 | Loopback active |
| extLoop | input | 1 | External (1) or internal (0) loopback |
| tpSelect | input | 1 | Twisted-pair port selected |
| runtCfg | input | 1 | Stored runt-accept setting |
| addrFilter | input | 64 | Logical address filter |
| rxValid | output | 1 | Looped-back byte valid |
| rxByte | output | 8 | Looped-back byte |
| rxSof | output | 1 | First looped-back byte |
| rxEof | output | 1 | Last looped-back byte |
| netTxEn | output | 1 | Byte would be driven onto the wire |
| fcsErr | output | 1 | Check sequence mismatch |
| mcastAccept | output | 1 | Multicast hash hit |
| runtAccept | output | 1 | Effective runt acceptance |
| collisionEn | output | 1 | Collision detection enabled |

## Verification
Frames run under both ownership modes. With the transmit side as owner, the test tells whether the four appended bytes hold the right complemented CRC in the right byte order. With the receive side as owner, it shows that nothing is appended and the check passes. A frame with one corrupted check byte must raise `fcsErr`. Group addresses whose hash index points to a set filter bit and to a cleared one tell the index computation apart from a constant. A frame whose ownership input flips after the first byte, and single-byte frames in both modes, probe the per-frame sampling and the length corner. Sweeps over the loopback flags cover runt forcing, collision masking and wire marking.

// File: rtl/lb_crc_pkg.sv
package lb_crc_pkg;
  localparam int FCS_BYTES = 4;
  localparam int SEL_W = $clog2(FCS_BYTES);
  localparam logic [31:0] CRC_POLY_REFL = 32'hEDB88320;
  localparam logic [31:0] CRC_GOOD_REFL = 32'hDEBB20E3;

  typedef struct packed {
    logic crcInit;
    logic crcUpd;
    logic pass;
    logic emitFcs;
    logic [SEL_W-1:0] fcsSel;
    logic lastOut;
    logic checkNow;
    logic hashNow;
    logic ownerRx;
  } lbStrobe_t;

  function automatic logic [31:0] crcStep(input logic [31:0] c, input logic [7:0] d);
    logic [31:0] r;
    r = c;
    for (int i = 0; i < 8; i++) begin
      if (r[0] ^ d[i]) r = (r >> 1) ^ CRC_POLY_REFL;
      else r = r >> 1;
    end
    return r;
  endfunction
endpackage

// File: rtl/lb_ctrl.sv
module lb_ctrl
  import lb_crc_pkg::*;
#(
  parameter int DA_BYTES = 6
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      txValid,
  input  logic      txSof,
  input  logic      txEof,
  input  logic      crcToRx,
  output logic      txReady,
  output lbStrobe_t strb
);
  localparam int CNT_W = $clog2(DA_BYTES + 2);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(DA_BYTES + 1);

  logic appending;
  logic [SEL_W-1:0] appCnt;
  logic ownerRx;
  logic [CNT_W-1:0] byteCnt;
  logic acc, ownNow;

  assign txReady = !appending;
  assign acc     = txValid && !appending;
  assign ownNow  = txSof ? crcToRx : ownerRx;

  always_comb begin
    strb.crcInit  = acc && txSof;
    strb.crcUpd   = acc;
    strb.pass     = acc;
    strb.emitFcs  = appending;
    strb.fcsSel   = appCnt;
    strb.checkNow = acc && txEof && ownNow;
    strb.lastOut  = (acc && txEof && ownNow) ||
                    (appending && appCnt == SEL_W'(FCS_BYTES - 1));
    strb.hashNow  = acc && ownNow && !txSof && (byteCnt == CNT_W'(DA_BYTES - 1));
    strb.ownerRx  = ownNow;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      appending <= 1'b0;
      appCnt    <= '0;
      ownerRx   <= 1'b0;
      byteCnt   <= '0;
    end else begin
      if (acc && txSof) ownerRx <= crcToRx;
      if (acc) begin
        if (txSof) byteCnt <= CNT_W'(1);
        else if (byteCnt != CNT_MAX) byteCnt <= byteCnt + 1'b1;
      end
      if (acc && txEof && !ownNow) begin
        appending <= 1'b1;
        appCnt    <= '0;
      end else if (appending) begin
        appCnt <= appCnt + 1'b1;
        if (appCnt == SEL_W'(FCS_BYTES - 1)) appending <= 1'b0;
      end
    end
  end

  // R1: ownership only moves with an accepted start byte
  a_r1_owner_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(acc && txSof) |=> $stable(ownerRx));
  // R2: transmit-owned frame end starts the append
  a_r2_append_starts: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && txEof && !ownNow) |=> (appending && !txReady));
  // R4: receive-owned frame end never appends
  a_r4_no_append: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && txEof && ownNow) |=> !appending);
endmodule

// File: rtl/lb_datapath.sv
module lb_datapath
  import lb_crc_pkg::*;
#(
  parameter int FILTER_BITS = 64
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  lbStrobe_t              strb,
  input  logic [7:0]             txByte,
  input  logic                   txSof,
  input  logic                   loopEn,
  input  logic                   extLoop,
  input  logic [FILTER_BITS-1:0] addrFilter,
  output logic                   rxValid,
  output logic [7:0]             rxByte,
  output logic                   rxSof,
  output logic                   rxEof,
  output logic                   netTxEn,
  output logic                   fcsErr,
  output logic                   mcastAccept
);
  localparam int IDX_W = $clog2(FILTER_BITS);

  logic [31:0] crcReg, crcIn, crcNext;
  logic daGroup;
  logic outValid;
  logic [7:0] outByte;
  logic [31:0] fcsWord;

  assign crcIn    = strb.crcInit ? 32'hFFFF_FFFF : crcReg;
  assign crcNext  = crcStep(crcIn, txByte);
  assign fcsWord  = ~crcReg;
  assign outValid = strb.pass || strb.emitFcs;
  assign outByte  = strb.emitFcs ? fcsWord[8*strb.fcsSel +: 8] : txByte;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      crcReg      <= '1;
      daGroup     <= 1'b0;
      rxValid     <= 1'b0;
      rxByte      <= '0;
      rxSof       <= 1'b0;
      rxEof       <= 1'b0;
      netTxEn     <= 1'b0;
      fcsErr      <= 1'b0;
      mcastAccept <= 1'b0;
    end else begin
      if (strb.crcUpd) crcReg <= crcNext;
      if (strb.crcInit) daGroup <= txByte[0];
      rxValid <= outValid && loopEn;
      netTxEn <= outValid && !(loopEn && !extLoop);
      rxByte  <= outByte;
      rxSof   <= strb.pass && txSof;
      rxEof   <= strb.lastOut;
      if (strb.checkNow) fcsErr <= (crcNext != CRC_GOOD_REFL);
      else if (strb.crcInit) fcsErr <= 1'b0;
      if (strb.hashNow) mcastAccept <= daGroup && addrFilter[crcNext[IDX_W-1:0]];
      else if (strb.crcInit) mcastAccept <= 1'b0;
    end
  end

  // R5: error flag moves only at frame end or frame start
  a_r5_err_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !(strb.checkNow || strb.crcInit) |=> $stable(fcsErr));
  // R9: nothing looped back while loopback is off
  a_r9_no_loop_out: assert property (@(posedge clk) disable iff (!rst_n)
    !loopEn |=> !rxValid);
  // R3: receive checks stay quiet for transmit-owned frames
  a_r3_quiet_tx_owner: assert property (@(posedge clk) disable iff (!rst_n)
    (strb.crcInit && !strb.checkNow && !strb.ownerRx) |=> (!fcsErr && !mcastAccept));
endmodule

// File: rtl/lb_crc_path.sv
module lb_crc_path
  import lb_crc_pkg::*;
#(
  parameter int FILTER_BITS = 64,
  parameter int DA_BYTES    = 6
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   txValid,
  input  logic [7:0]             txByte,
  input  logic                   txSof,
  input  logic                   txEof,
  output logic                   txReady,
  input  logic                   crcToRx,
  input  logic                   loopEn,
  input  logic                   extLoop,
  input  logic                   tpSelect,
  input  logic                   runtCfg,
  input  logic [FILTER_BITS-1:0] addrFilter,
  output logic                   rxValid,
  output logic [7:0]             rxByte,
  output logic                   rxSof,
  output logic                   rxEof,
  output logic                   netTxEn,
  output logic                   fcsErr,
  output logic                   mcastAccept,
  output logic                   runtAccept,
  output logic                   collisionEn
);
  lbStrobe_t strb;

  lb_ctrl #(.DA_BYTES(DA_BYTES)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .txValid(txValid), .txSof(txSof), .txEof(txEof),
    .crcToRx(crcToRx), .txReady(txReady), .strb(strb)
  );

  lb_datapath #(.FILTER_BITS(FILTER_BITS)) u_dp (
    .clk(clk), .rst_n(rst_n), .strb(strb), .txByte(txByte), .txSof(txSof),
    .loopEn(loopEn), .extLoop(extLoop), .addrFilter(addrFilter),
    .rxValid(rxValid), .rxByte(rxByte), .rxSof(rxSof), .rxEof(rxEof),
    .netTxEn(netTxEn), .fcsErr(fcsErr), .mcastAccept(mcastAccept)
  );

  assign runtAccept  = runtCfg || loopEn;
  assign collisionEn = !(loopEn && extLoop && tpSelect);

  // R7: loopback forces runt acceptance
  a_r7_runt_forced: assert property (@(posedge clk) disable iff (!rst_n)
    loopEn |-> runtAccept);
  // R8: external twisted-pair loopback masks collisions
  a_r8_col_masked: assert property (@(posedge clk) disable iff (!rst_n)
    (loopEn && extLoop && tpSelect) |-> !collisionEn);
endmodule

// File: tb/lb_crc_path_tb.sv
module lb_crc_path_tb;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic txValid = 1'b0, txSof = 1'b0, txEof = 1'b0;
  logic [7:0] txByte = '0;
  logic txReady;
  logic crcToRx = 1'b0, loopEn = 1'b0, extLoop = 1'b0, tpSelect = 1'b0, runtCfg = 1'b0;
  logic [63:0] addrFilter = '0;
  logic rxValid, rxSof, rxEof, netTxEn, fcsErr, mcastAccept, runtAccept, collisionEn;
  logic [7:0] rxByte;

  int errors = 0;
  int checks = 0;
  bit finished = 1'b0;

  logic [7:0] frame[$];
  logic [7:0] got[$];
  bit gotEof[$];
  int netCnt;

  always #(CLK_PERIOD/2) clk = ~clk;

  lb_crc_path u_dut (
    .clk(clk), .rst_n(rst_n), .txValid(txValid), .txByte(txByte), .txSof(txSof),
    .txEof(txEof), .txReady(txReady), .crcToRx(crcToRx), .loopEn(loopEn),
    .extLoop(extLoop), .tpSelect(tpSelect), .runtCfg(runtCfg), .addrFilter(addrFilter),
    .rxValid(rxValid), .rxByte(rxByte), .rxSof(rxSof), .rxEof(rxEof), .netTxEn(netTxEn),
    .fcsErr(fcsErr), .mcastAccept(mcastAccept), .runtAccept(runtAccept),
    .collisionEn(collisionEn)
  );

  always @(negedge clk) begin
    if (rxValid) begin
      got.push_back(rxByte);
      gotEof.push_back(rxEof);
    end
    if (netTxEn) netCnt++;
  end

  function automatic logic [31:0] refCrc(input logic [31:0] c, input logic [7:0] d);
    logic [31:0] r;
    r = c;
    for (int b = 0; b < 8; b++) begin
      logic fb;
      fb = r[0] ^ d[b];
      r = {1'b0, r[31:1]};
      if (fb) r = r ^ 32'hEDB88320;
    end
    return r;
  endfunction

  function automatic logic [31:0] frameCrc(input int n);
    logic [31:0] c;
    c = 32'hFFFF_FFFF;
    for (int i = 0; i < n; i++) c = refCrc(c, frame[i]);
    return c;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic buildFrame(input int n, input logic [7:0] first, input logic [7:0] seed);
    frame.delete();
    frame.push_back(first);
    for (int i = 1; i < n; i++) frame.push_back(8'(seed + 8'(i * 29)));
  endtask

  task automatic addFcs();
    logic [31:0] f;
    f = ~frameCrc(frame.size());
    for (int k = 0; k < 4; k++) frame.push_back(f[8*k +: 8]);
  endtask

  task automatic sendFrame(input bit mode, input bit flipMid);
    got.delete();
    gotEof.delete();
    netCnt = 0;
    for (int i = 0; i < frame.size(); i++) begin
      @(negedge clk);
      while (!txReady) @(negedge clk);
      txValid = 1'b1;
      txByte  = frame[i];
      txSof   = (i == 0);
      txEof   = (i == frame.size() - 1);
      crcToRx = (flipMid && i > 0) ? !mode : mode;
    end
    @(negedge clk);
    txValid = 1'b0; txSof = 1'b0; txEof = 1'b0;
    repeat (8) @(negedge clk);
  endtask

  task automatic checkPassThrough(input string req);
    bit same;
    same = (got.size() == frame.size());
    for (int i = 0; i < got.size() && same; i++) if (got[i] !== frame[i]) same = 1'b0;
    chk(same, req, got.size(), frame.size());
    chk(got.size() > 0 && gotEof[got.size()-1] && $countones(gotEof.size()) >= 0, req,
        got.size() > 0 ? 32'(gotEof[got.size()-1]) : 0, 1);
  endtask

  task automatic testReset();
    chk(!rxValid && txReady && !fcsErr && !mcastAccept && !netTxEn, "R10 reset",
        {rxValid, txReady, fcsErr, mcastAccept, netTxEn}, 5'b01000);
    chk(collisionEn && !runtAccept, "R8 reset", {collisionEn, runtAccept}, 2'b10);
  endtask

  task automatic testTxOwner();
    logic [31:0] f;
    bit ok;
    loopEn = 1'b1; extLoop = 1'b0; addrFilter = '1;
    buildFrame(8, 8'h01, 8'h35);
    f = ~frameCrc(8);
    sendFrame(1'b0, 1'b0);
    chk(got.size() == 12, "R2 length", got.size(), 12);
    ok = (got.size() == 12);
    for (int i = 0; i < 8 && ok; i++) if (got[i] !== frame[i]) ok = 1'b0;
    chk(ok, "R2 payload", 0, 0);
    for (int k = 0; k < 4; k++)
      if (got.size() == 12) chk(got[8+k] === f[8*k +: 8], "R2 fcs byte", got[8+k], f[8*k +: 8]);
    chk(got.size() == 12 && gotEof[11] && !gotEof[7], "R2 eof position", 0, 0);
    chk(!fcsErr && !mcastAccept, "R3 receive side quiet", {fcsErr, mcastAccept}, 0);
  endtask

  task automatic testRxOwner();
    logic [31:0] c;
    loopEn = 1'b1; extLoop = 1'b0;
    buildFrame(10, 8'h03, 8'h11);
    c = frameCrc(6);
    addrFilter = '0;
    addrFilter[c[5:0]] = 1'b1;
    addFcs();
    sendFrame(1'b1, 1'b0);
    checkPassThrough("R4 no append");
    chk(!fcsErr, "R5 good fcs", fcsErr, 0);
    chk(mcastAccept, "R6 hash hit", mcastAccept, 1);
    addrFilter = '1;
    addrFilter[c[5:0]] = 1'b0;
    sendFrame(1'b1, 1'b0);
    chk(!mcastAccept, "R6 hash miss", mcastAccept, 0);
    addrFilter = '1;
    frame[0] = 8'h02;
    frame.delete(frame.size()-1); frame.delete(frame.size()-1);
    frame.delete(frame.size()-1); frame.delete(frame.size()-1);
    addFcs();
    sendFrame(1'b1, 1'b0);
    chk(!mcastAccept && !fcsErr, "R6 individual address", {mcastAccept, fcsErr}, 0);
    frame[frame.size()-2] = frame[frame.size()-2] ^ 8'h40;
    sendFrame(1'b1, 1'b0);
    chk(fcsErr, "R5 bad fcs", fcsErr, 1);
    buildFrame(12, 8'h01, 8'h22);
    addFcs();
    sendFrame(1'b1, 1'b0);
    chk(!fcsErr, "R5 cleared next frame", fcsErr, 0);
  endtask

  task automatic testOwnerFlip();
    loopEn = 1'b1;
    buildFrame(9, 8'h05, 8'h77);
    addFcs();
    sendFrame(1'b1, 1'b1);
    chk(got.size() == frame.size(), "R1 rx owner kept", got.size(), frame.size());
    chk(!fcsErr, "R1 check still done", fcsErr, 0);
    buildFrame(7, 8'h01, 8'h19);
    sendFrame(1'b0, 1'b1);
    chk(got.size() == 11, "R1 tx owner kept", got.size(), 11);
  endtask

  task automatic testShort();
    logic [31:0] f;
    loopEn = 1'b1; addrFilter = '1;
    buildFrame(1, 8'hA5, 8'h00);
    f = ~frameCrc(1);
    sendFrame(1'b0, 1'b0);
    chk(got.size() == 5 && got[0] == 8'hA5 && got[4] == f[31:24] && gotEof[4],
        "R10 one byte tx owner", got.size(), 5);
    buildFrame(3, 8'h01, 8'h40);
    sendFrame(1'b1, 1'b0);
    chk(got.size() == 3 && gotEof[2], "R10 three bytes rx owner", got.size(), 3);
    chk(!mcastAccept && fcsErr, "R6 short frame no hash", {mcastAccept, fcsErr}, 2'b01);
  endtask

  task automatic testFlags();
    for (int v = 0; v < 16; v++) begin
      @(negedge clk);
      {loopEn, extLoop, tpSelect, runtCfg} = 4'(v);
      #1;
      chk(runtAccept == (runtCfg | loopEn), "R7 runt", runtAccept, runtCfg | loopEn);
      chk(collisionEn == !(loopEn && extLoop && tpSelect), "R8 collision", collisionEn,
          !(loopEn && extLoop && tpSelect));
    end
    tpSelect = 1'b0; runtCfg = 1'b0;
  endtask

  task automatic testPaths();
    buildFrame(6, 8'h01, 8'h55);
    loopEn = 1'b1; extLoop = 1'b0;
    sendFrame(1'b0, 1'b0);
    chk(got.size() == 10 && netCnt == 0, "R9 internal no wire", netCnt, 0);
    extLoop = 1'b1;
    sendFrame(1'b0, 1'b0);
    chk(got.size() == 10 && netCnt == 10, "R9 external both", netCnt, 10);
    loopEn = 1'b0;
    sendFrame(1'b0, 1'b0);
    chk(got.size() == 0 && netCnt == 10, "R9 loop off", got.size(), 0);
    extLoop = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    testReset();
    testTxOwner();
    testRxOwner();
    testOwnerFlip();
    testShort();
    testFlags();
    testPaths();
    if (!finished) begin
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!finished) begin
      finished = 1'b1;
      errors++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule